// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block holds the interrupt state of a memory-mapped serial port. It keeps ten sticky interrupt flags and a ten-bit mask. A single level interrupt line is raised while any flag that is set is also enabled in the mask. Five of the flags follow live conditions reported by the FIFO logic. While such a condition input is high, its flag is forced to one on every clock. The other five flags are set by one-cycle event pulses.

Software reaches the block through a simple single-cycle write strobe and a combinational read port. The mask is never written directly. One address sets mask bits, and another address clears them. The flag register is cleared by writing ones. When a flag is set and cleared in the same cycle, the set wins.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset the mask and all flags are zero and `irq_o` is low.
- R2: Live condition inputs map to flag bits as follows: bit0 receive trigger level reached, bit1 receive FIFO empty, bit2 receive FIFO full, bit3 transmit FIFO empty, bit4 transmit FIFO full. A live input that is high at a clock edge leaves its flag at 1 after that edge.
- R3: Event pulse inputs map to flag bits as follows: event0 to bit5 (receive overflow), event1 to bit6 (framing error), event2 to bit7 (parity error), event3 to bit8 (receive timeout), event4 to bit9 (modem status change). A one-cycle pulse sets its flag.
- R4: A flag stays at 1 after its source drops, until software clears it.
- R5: A write to offset 0x08 ORs `wdata_i[9:0]` into the mask.
- R6: A write to offset 0x0C clears each mask bit written as 1 and leaves the other mask bits unchanged.
- R7: A write to offset 0x10 (the mask read address) leaves the mask unchanged.
- R8: A write to offset 0x14 clears each flag written as 1 and leaves the flags written as 0 unchanged.
- R9: If a flag's source is active in the same cycle as a write that clears it, the flag ends the cycle at 1.
- R10: `irq_o` is high exactly when the bitwise AND of the mask and the flags is nonzero.
- R11: A read at 0x10 returns the mask, and a read at 0x14 returns the flags, both zero-extended. Every other offset reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_i | input | 1 | Register write strobe, one write per cycle |
| addr_i | input | ADDR_W | Byte offset of the register access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| live_i | input | 5 | Live FIFO condition levels |
| evt_i | input | 5 | One-cycle event pulses |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench drives a live input high in the same cycle as a write that clears its flag. A design that lets the clear win would drop a condition that is still present. It clears flags with partial masks, checking that a design which clears the whole register, or ignores zero bits incorrectly, leaves the wrong survivors. It writes the mask's read address with all ones to catch a mask that accepts direct writes. It also drives overlapping enable and disable sequences to catch a disable that clears bits written as zero. Finally, the bench raises and lowers the interrupt by changing only the mask and only the flags. This exposes an interrupt line that ignores one of the two operands.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NUM_LIVE = 5;
  localparam int NUM_EVT  = 5;
  localparam int IRQ_W    = NUM_LIVE + NUM_EVT;

  localparam int OFF_ENABLE  = 'h08;
  localparam int OFF_DISABLE = 'h0C;
  localparam int OFF_MASK    = 'h10;
  localparam int OFF_STATUS  = 'h14;

  typedef logic [IRQ_W-1:0] irq_vec_t;
endpackage

// File: rtl/uirq_decode.sv
module uirq_decode #(
  parameter int ADDR_W = 8
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              we_set_o,
  output logic              we_clr_o,
  output logic              we_ack_o,
  output logic              sel_mask_o,
  output logic              sel_stat_o
);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(uirq_pkg::OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(uirq_pkg::OFF_DISABLE);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(uirq_pkg::OFF_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(uirq_pkg::OFF_STATUS);

  always_comb begin
    sel_mask_o = (addr_i == A_MASK);
    sel_stat_o = (addr_i == A_STAT);
    we_set_o   = wr_i && (addr_i == A_EN);
    we_clr_o   = wr_i && (addr_i == A_DIS);
    we_ack_o   = wr_i && sel_stat_o;
  end
endmodule

// File: rtl/uirq_mask.sv
module uirq_mask
  import uirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we_set_i,
  input  logic     we_clr_i,
  input  logic     wr_any_i,
  input  logic     sel_mask_i,
  input  irq_vec_t wbits_i,
  output irq_vec_t mask_o
);
  irq_vec_t mask_q, mask_d;
  logic     mask_en;

  always_comb begin
    mask_en = we_set_i | we_clr_i;
    mask_d  = mask_q;
    if (we_set_i) mask_d = mask_q | wbits_i;
    else if (we_clr_i) mask_d = mask_q & ~wbits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  p_enable_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we_set_i |=> ((mask_q & $past(wbits_i)) == $past(wbits_i)));
  p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr_i |=> ((mask_q & $past(wbits_i)) == '0));
  p_mask_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any_i && sel_mask_i) |=> $stable(mask_q));
endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky
  import uirq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_LIVE-1:0] live_i,
  input  logic [NUM_EVT-1:0]  evt_i,
  input  logic                we_ack_i,
  input  irq_vec_t            wbits_i,
  output irq_vec_t            flags_o
);
  irq_vec_t flags_q, flags_d, src;

  assign src = {evt_i, live_i};

  for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
    always_comb begin
      flags_d[b] = flags_q[b];
      if (we_ack_i && wbits_i[b]) flags_d[b] = 1'b0;
      if (src[b]) flags_d[b] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  p_live_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i != '0) |=> ((flags_q[NUM_LIVE-1:0] & $past(live_i)) == $past(live_i)));
  p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((flags_q[IRQ_W-1:NUM_LIVE] & $past(evt_i)) == $past(evt_i)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_ack_i && src == '0) |=> $stable(flags_q));
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_ack_i && src == '0) |=> ((flags_q & $past(wbits_i)) == '0));
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_LIVE-1:0] live_i,
  input  logic [NUM_EVT-1:0]  evt_i,
  output logic                irq_o
);
  localparam int PAD_W = DATA_W - IRQ_W;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       we_set, we_clr, we_ack, sel_mask, sel_stat;
  irq_vec_t   wbits, mask, flags;
  logic [PAD_W-1:0] unused_wdata_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wbits           = wdata_i[IRQ_W-1:0];
  assign unused_wdata_hi = wdata_i[DATA_W-1:IRQ_W];

  uirq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i(wr_i), .addr_i(addr_i), .we_set_o(we_set), .we_clr_o(we_clr),
    .we_ack_o(we_ack), .sel_mask_o(sel_mask), .sel_stat_o(sel_stat)
  );

  uirq_mask u_mask (
    .clk(clk), .rst_n(rst_int_n), .we_set_i(we_set), .we_clr_i(we_clr),
    .wr_any_i(wr_i), .sel_mask_i(sel_mask), .wbits_i(wbits), .mask_o(mask)
  );

  uirq_sticky u_flags (
    .clk(clk), .rst_n(rst_int_n), .live_i(live_i), .evt_i(evt_i),
    .we_ack_i(we_ack), .wbits_i(wbits), .flags_o(flags)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_mask) rdata_o = {{PAD_W{1'b0}}, mask};
    else if (sel_stat) rdata_o = {{PAD_W{1'b0}}, flags};
  end

  assign irq_o = |(mask & flags);

  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flags == '0) |-> !irq_o);
  p_irq_needs_mask_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask == '0) |-> !irq_o);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (we_ack && (live_i[0] || evt_i[0])) |=> (flags[0] || flags[NUM_LIVE]));
endmodule

// File: tb/tb_uirq_ctrl.sv
module tb_uirq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_i;
  logic [7:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic [4:0]  live_i;
  logic [4:0]  evt_i;
  logic        irq_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  uirq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .live_i(live_i), .evt_i(evt_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  task automatic pulse(input logic [4:0] lv, input logic [4:0] ev);
    @(negedge clk);
    live_i = lv; evt_i = ev;
    @(negedge clk);
    live_i = '0; evt_i = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h10, d); check("R1 mask", d, 32'h0);
    rd(8'h14, d); check("R1 flags", d, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_live;
    logic [31:0] d;
    pulse(5'b10101, 5'b0);
    rd(8'h14, d); check("R2 live map", d, 32'h15);
    check("R10 irq masked", {31'b0, irq_o}, 32'h0);
    repeat (3) @(negedge clk);
    rd(8'h14, d); check("R4 flags held", d, 32'h15);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); check("R8 clear all", d, 32'h0);
  endtask

  task automatic t_event;
    logic [31:0] d;
    pulse(5'b0, 5'b01010);
    rd(8'h14, d); check("R3 event map", d, 32'h140);
    wr(8'h14, 32'h040);
    rd(8'h14, d); check("R8 partial clear", d, 32'h100);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(8'h08, 32'h105);
    rd(8'h10, d); check("R5 enable", d, 32'h105);
    wr(8'h08, 32'h00A);
    rd(8'h10, d); check("R5 enable or", d, 32'h10F);
    wr(8'h0C, 32'h005);
    rd(8'h10, d); check("R6 disable", d, 32'h10A);
    wr(8'h10, 32'h3FF);
    rd(8'h10, d); check("R7 mask write ignored", d, 32'h10A);
    wr(8'h10, 32'h000);
    rd(8'h10, d); check("R7 mask zero write ignored", d, 32'h10A);
  endtask

  task automatic t_irq;
    @(negedge clk);
    check("R10 irq on", {31'b0, irq_o}, 32'h1);
    wr(8'h0C, 32'h100);
    check("R10 irq off by mask", {31'b0, irq_o}, 32'h0);
    wr(8'h08, 32'h001);
    check("R10 irq off no flag", {31'b0, irq_o}, 32'h0);
    pulse(5'b00001, 5'b0);
    check("R10 irq on by flag", {31'b0, irq_o}, 32'h1);
    wr(8'h14, 32'h001);
    check("R10 irq off after clear", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    wr(8'h14, 32'h3FF);
    @(negedge clk);
    live_i = 5'b01000;
    wr_i = 1'b1; addr_i = 8'h14; wdata_i = 32'h008;
    @(negedge clk);
    wr_i = 1'b0; live_i = '0;
    rd(8'h14, d); check("R9 set wins", d, 32'h008);
    wr(8'h14, 32'h008);
    rd(8'h14, d); check("R8 clear after source gone", d, 32'h0);
  endtask

  task automatic t_readmap;
    logic [31:0] d;
    pulse(5'b11111, 5'b11111);
    rd(8'h14, d); check("R11 flags read", d, 32'h3FF);
    rd(8'h08, d); check("R11 enable reads zero", d, 32'h0);
    rd(8'h0C, d); check("R11 disable reads zero", d, 32'h0);
    rd(8'h00, d); check("R11 other reads zero", d, 32'h0);
  endtask

  initial begin
    wr_i = 0; addr_i = '0; wdata_i = '0; live_i = '0; evt_i = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_live();
    t_event();
    t_mask();
    t_irq();
    t_set_wins();
    t_readmap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #50000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule